// File: doc/BRIEF.md
# Receive Transfer Address Tracker

This block follows the bus byte address of the next location still to be read during a receive packet transfer. Software programs a start address through a small register write port. From then on, each data beat that the bus engine reports as successful moves the address forward by that beat's byte count. A beat reported as failed leaves the address where it was. The value therefore stays exact even when the transfer ends through an abnormal bus termination.

When a packet transfer ends, the bus engine presents a termination event with a cause code. There are five causes: normal completion, initiator abort, target abort, retry abort and system error. Each cause sets its own sticky status bit, and software clears these bits by writing ones to them. Each cause also has its own interrupt enable bit. The interrupt output is asserted while any status bit is set and its enable bit is also set. A status bit is recorded even when its enable bit is clear, so a polling controller still sees every ending.

Register select codes are used on both the write and the read side:
- 0 selects the start address on writes and the next address on reads.
- 1 selects the interrupt enable word.
- 2 selects the status word.
- 3 reads as zero.

Top module: `rx_addr_tracker`

## Requirements
- R1: After reset, the next address, the enable word and the status word all read zero, and `irq` is low.
- R2: A beat with `beat_valid`=1 and `beat_ok`=1 adds `beat_bytes` (a value from 0 to 4) to the next address. The sum wraps modulo 2^32, and the new value is readable one cycle later.
- R3: A write with select 0 loads `wr_data` into the next address, and the new value is readable on the following cycle.
- R4: A beat with `beat_ok`=0 leaves the next address unchanged.
- R5: When a select-0 write and a successful beat occur in the same cycle, the next address takes the written value.
- R6: A termination event with cause code 0 (normal), 1 (initiator abort), 2 (target abort), 3 (retry abort) or 4 (system error) sets the status bit with the same index. That bit stays set until it is cleared. Cause codes 5 to 7 change nothing.
- R7: `irq` is high exactly when some status bit is set and the enable bit at the same index is set. A status bit is still set by its event while its enable bit is clear.
- R8: In the enable word (select 1), bits 4:0 are writable and readable. Bits 31:5 read as zero whatever was written to them; this includes the reserved upper 16 bits.
- R9: A write with select 2 clears every status bit whose data bit is 1 and keeps all other status bits. If a bit is set by an event in the same cycle as it is cleared, the set wins.
- R10: Termination events and status or enable writes do not change the next address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 2 | Write register select |
| wr_data | input | 32 | Write data |
| beat_valid | input | 1 | Data beat completed this cycle |
| beat_ok | input | 1 | The completed beat was successful |
| beat_bytes | input | 3 | Bytes moved by the beat |
| term_valid | input | 1 | Transfer termination event |
| term_cause | input | 3 | Termination cause code |
| rd_sel | input | 2 | Read register select |
| rd_data | output | 32 | Read data (combinational) |
| irq | output | 1 | Interrupt request |

## Verification
The hardest situations to reach from the ports are two same-cycle collisions. In the first, a start-address write meets a successful beat. In the second, a write-one-to-clear meets a new termination event for the same bit. The directed tasks drive both inputs on the same falling edge so that they reach the register together, and they check the result one edge later. Long runs of mixed byte counts, failed beats and reloads are compared against a reference counter in the bench. One task starts just below the top of the address space so that the count wraps.

// File: rtl/rx_addr_pkg.sv
// Package: shared constants and types for the receive address tracker.
// Assumes cause codes index the status and enable bit positions directly.
package rx_addr_pkg;
    localparam int ADDR_W     = 32;
    localparam int CNT_W      = 3;
    localparam int NUM_CAUSES = 5;
    localparam int SEL_W      = 2;

    typedef enum logic [2:0] {
        CAUSE_NORMAL = 3'd0,
        CAUSE_INIT   = 3'd1,
        CAUSE_TGT    = 3'd2,
        CAUSE_RETRY  = 3'd3,
        CAUSE_SYSERR = 3'd4
    } cause_e;

    typedef enum logic [SEL_W-1:0] {
        SEL_ADDR   = 2'd0,
        SEL_ENABLE = 2'd1,
        SEL_STATUS = 2'd2,
        SEL_NONE   = 2'd3
    } sel_e;
endpackage

// File: rtl/rx_next_addr.sv
// Module: next-address counter. Loads a start value or advances by the
// byte count of a successful beat; a load wins over an advance.
// Assumes step_en is already qualified by beat success.
module rx_next_addr #(
    parameter int ADDR_W = 32,
    parameter int CNT_W  = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load_en,
    input  logic [ADDR_W-1:0] load_val,
    input  logic              step_en,
    input  logic [CNT_W-1:0]  step_bytes,
    output logic [ADDR_W-1:0] addr_q
);
    localparam int PAD_W = ADDR_W - CNT_W;

    logic [ADDR_W-1:0] step_ext;

    // Widen the beat byte count to the address width.
    always_comb begin
        step_ext = {{PAD_W{1'b0}}, step_bytes};
    end

    // Address register: reset, reload with priority, else advance.
    always_ff @(posedge clk) begin
        if (!rst_n)        addr_q <= '0;
        else if (load_en)  addr_q <= load_val;
        else if (step_en)  addr_q <= addr_q + step_ext;
    end
endmodule

// File: rtl/rx_term_status.sv
// Module: per-cause sticky status, enable bits and interrupt combine.
// Assumes the cause code equals the bit index; codes at or above NUM_CAUSES
// are ignored. A set beats a write-one-to-clear in the same cycle.
module rx_term_status #(
    parameter int NUM_CAUSES = 5,
    parameter int CODE_W     = 3
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  en_wr,
    input  logic [NUM_CAUSES-1:0] en_wdata,
    input  logic                  clr_wr,
    input  logic [NUM_CAUSES-1:0] clr_mask,
    input  logic                  term_valid,
    input  logic [CODE_W-1:0]     term_cause,
    output logic [NUM_CAUSES-1:0] en_q,
    output logic [NUM_CAUSES-1:0] status_q,
    output logic                  irq
);
    logic [NUM_CAUSES-1:0] set_vec;

    // Enable register: loaded whole on an enable write.
    always_ff @(posedge clk) begin
        if (!rst_n)     en_q <= '0;
        else if (en_wr) en_q <= en_wdata;
    end

    genvar gi;
    generate
        for (gi = 0; gi < NUM_CAUSES; gi++) begin : g_cause
            // Decode: this cause's event arrives this cycle.
            always_comb begin
                set_vec[gi] = term_valid && (term_cause == CODE_W'(gi));
            end

            // Sticky bit: set has priority over write-one-to-clear.
            always_ff @(posedge clk) begin
                if (!rst_n)                        status_q[gi] <= 1'b0;
                else if (set_vec[gi])              status_q[gi] <= 1'b1;
                else if (clr_wr && clr_mask[gi])   status_q[gi] <= 1'b0;
            end
        end
    endgenerate

    // Interrupt: any recorded cause whose enable is on.
    always_comb begin
        irq = |(status_q & en_q);
    end
endmodule

// File: rtl/rx_reg_read.sv
// Module: read multiplexer. Narrow registers are zero-extended, so the
// reserved bits always read zero. Assumes DATA_W >= NUM_CAUSES.
module rx_reg_read #(
    parameter int DATA_W     = 32,
    parameter int NUM_CAUSES = 5,
    parameter int SEL_W      = 2
) (
    input  logic [SEL_W-1:0]      rd_sel,
    input  logic [DATA_W-1:0]     addr_q,
    input  logic [NUM_CAUSES-1:0] en_q,
    input  logic [NUM_CAUSES-1:0] status_q,
    output logic [DATA_W-1:0]     rd_data
);
    import rx_addr_pkg::*;
    localparam int PAD_W = DATA_W - NUM_CAUSES;

    // Select the register addressed by rd_sel.
    always_comb begin
        case (rd_sel)
            SEL_ADDR:   rd_data = addr_q;
            SEL_ENABLE: rd_data = {{PAD_W{1'b0}}, en_q};
            SEL_STATUS: rd_data = {{PAD_W{1'b0}}, status_q};
            default:    rd_data = '0;
        endcase
    end
endmodule

// File: rtl/rx_addr_tracker.sv
// Module: top of the receive transfer address tracker. Decodes register
// writes, qualifies beats by success and wires the counter, status and
// read mux. Assumes single-cycle strobes from the bus engine.
module rx_addr_tracker
    import rx_addr_pkg::*;
#(
    parameter int DW = ADDR_W,
    parameter int BW = CNT_W,
    parameter int NC = NUM_CAUSES
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  logic [1:0]    wr_sel,
    input  logic [DW-1:0] wr_data,
    input  logic          beat_valid,
    input  logic          beat_ok,
    input  logic [BW-1:0] beat_bytes,
    input  logic          term_valid,
    input  logic [2:0]    term_cause,
    input  logic [1:0]    rd_sel,
    output logic [DW-1:0] rd_data,
    output logic          irq
);
    logic          ld_addr, wr_enable, wr_status, beat_good;
    logic [DW-1:0] next_addr;
    logic [NC-1:0] irq_en, status;

    // Write decode and beat qualification.
    always_comb begin
        ld_addr   = wr_en && (wr_sel == SEL_ADDR);
        wr_enable = wr_en && (wr_sel == SEL_ENABLE);
        wr_status = wr_en && (wr_sel == SEL_STATUS);
        beat_good = beat_valid && beat_ok;
    end

    rx_next_addr #(.ADDR_W(DW), .CNT_W(BW)) u_addr (
        .clk(clk), .rst_n(rst_n),
        .load_en(ld_addr), .load_val(wr_data),
        .step_en(beat_good), .step_bytes(beat_bytes),
        .addr_q(next_addr)
    );

    rx_term_status #(.NUM_CAUSES(NC), .CODE_W(3)) u_stat (
        .clk(clk), .rst_n(rst_n),
        .en_wr(wr_enable), .en_wdata(wr_data[NC-1:0]),
        .clr_wr(wr_status), .clr_mask(wr_data[NC-1:0]),
        .term_valid(term_valid), .term_cause(term_cause),
        .en_q(irq_en), .status_q(status), .irq(irq)
    );

    rx_reg_read #(.DATA_W(DW), .NUM_CAUSES(NC), .SEL_W(2)) u_rd (
        .rd_sel(rd_sel), .addr_q(next_addr), .en_q(irq_en),
        .status_q(status), .rd_data(rd_data)
    );
endmodule

// File: rtl/rx_addr_tracker_chk.sv
// Module: assertion checker bound to rx_addr_tracker; observes ports and
// the internal next address, enable and status registers.
module rx_addr_tracker_chk #(
    parameter int DW = 32,
    parameter int BW = 3,
    parameter int NC = 5
) (
    input logic          clk,
    input logic          rst_n,
    input logic          wr_en,
    input logic [1:0]    wr_sel,
    input logic [DW-1:0] wr_data,
    input logic          beat_valid,
    input logic          beat_ok,
    input logic [BW-1:0] beat_bytes,
    input logic          term_valid,
    input logic [2:0]    term_cause,
    input logic [1:0]    rd_sel,
    input logic [DW-1:0] rd_data,
    input logic          irq,
    input logic [DW-1:0] next_addr,
    input logic [NC-1:0] irq_en,
    input logic [NC-1:0] status
);
    logic ld;
    always_comb ld = wr_en && (wr_sel == 2'd0);

    AST_ADVANCE: assert property (@(posedge clk) disable iff (!rst_n)
        (!ld && beat_valid && beat_ok) |=> next_addr == $past(next_addr) + DW'($past(beat_bytes))); // R2
    AST_RELOAD: assert property (@(posedge clk) disable iff (!rst_n)
        ld |=> next_addr == $past(wr_data)); // R3
    AST_NO_ADV_ON_FAIL: assert property (@(posedge clk) disable iff (!rst_n)
        (!ld && !(beat_valid && beat_ok)) |=> $stable(next_addr)); // R4
    AST_STATUS_SET: assert property (@(posedge clk) disable iff (!rst_n)
        (term_valid && term_cause < 3'd5) |=> status[$past(term_cause)]); // R6
    AST_IRQ_MASKED: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_en == '0) |-> !irq); // R7
    AST_RESERVED_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_sel == 2'd1) |-> (rd_data[DW-1:NC] == '0)); // R8
endmodule

bind rx_addr_tracker rx_addr_tracker_chk #(.DW(DW), .BW(BW), .NC(NC)) u_chk (.*);

// File: tb/tb_rx_addr_tracker.sv
// Directed bench: one task per scenario, each checking its own results
// against a reference next-address counter kept in the bench.
module tb_rx_addr_tracker;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [1:0]  wr_sel = 2'd0;
    logic [31:0] wr_data = '0;
    logic        beat_valid = 1'b0, beat_ok = 1'b0;
    logic [2:0]  beat_bytes = '0;
    logic        term_valid = 1'b0;
    logic [2:0]  term_cause = '0;
    logic [1:0]  rd_sel = 2'd0;
    logic [31:0] rd_data;
    logic        irq;

    int checks = 0, fails = 0;
    logic [31:0] ref_addr = '0;
    bit done = 0;

    always #2.5 clk = ~clk;

    rx_addr_tracker dut (.*);

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=0x%08h expected=0x%08h", req, act, exp);
        end
    endtask

    // Read a register combinationally between edges.
    task automatic rd(input logic [1:0] sel, output logic [31:0] v);
        rd_sel = sel; #0.5; v = rd_data;
    endtask

    task automatic wr(input logic [1:0] sel, input logic [31:0] d);
        @(negedge clk); wr_en = 1; wr_sel = sel; wr_data = d;
        @(negedge clk); wr_en = 0;
    endtask

    task automatic beat(input logic ok, input logic [2:0] n);
        @(negedge clk); beat_valid = 1; beat_ok = ok; beat_bytes = n;
        @(negedge clk); beat_valid = 0;
        if (ok) ref_addr = ref_addr + 32'(n);
    endtask

    task automatic term(input logic [2:0] c);
        @(negedge clk); term_valid = 1; term_cause = c;
        @(negedge clk); term_valid = 0;
    endtask

    task automatic t_reset();
        logic [31:0] v;
        @(negedge clk);
        rd(2'd0, v); check("R1 next addr", v, 0);
        rd(2'd1, v); check("R1 enable", v, 0);
        rd(2'd2, v); check("R1 status", v, 0);
        check("R1 irq", {31'b0, irq}, 0);
    endtask

    task automatic t_beats();
        logic [31:0] v;
        wr(2'd0, 32'h1000_0000); ref_addr = 32'h1000_0000;
        rd(2'd0, v); check("R3 reload", v, ref_addr);
        for (int i = 0; i < 40; i++) begin
            beat(1'b1, 3'(i % 5));
            rd(2'd0, v); check("R2 advance", v, ref_addr);
        end
    endtask

    task automatic t_mixed();
        logic [31:0] v;
        for (int i = 0; i < 60; i++) begin
            if (i % 7 == 3) begin
                wr(2'd0, 32'h0000_2000 + 32'(i * 16)); ref_addr = 32'h0000_2000 + 32'(i * 16);
                rd(2'd0, v); check("R3 reload in mix", v, ref_addr);
            end else if (i % 3 == 0) begin
                beat(1'b0, 3'd4);
                rd(2'd0, v); check("R4 failed beat holds", v, ref_addr);
            end else begin
                beat(1'b1, 3'd4);
                rd(2'd0, v); check("R2 mix advance", v, ref_addr);
            end
        end
    endtask

    task automatic t_collision();
        logic [31:0] v;
        @(negedge clk);
        wr_en = 1; wr_sel = 2'd0; wr_data = 32'hABCD_0000;
        beat_valid = 1; beat_ok = 1; beat_bytes = 3'd4;
        @(negedge clk); wr_en = 0; beat_valid = 0; ref_addr = 32'hABCD_0000;
        rd(2'd0, v); check("R5 load wins", v, ref_addr);
    endtask

    task automatic t_wrap();
        logic [31:0] v;
        wr(2'd0, 32'hFFFF_FFFE); ref_addr = 32'hFFFF_FFFE;
        beat(1'b1, 3'd4);
        rd(2'd0, v); check("R2 wrap", v, 32'h0000_0002);
    endtask

    task automatic t_enable_reserved();
        logic [31:0] v;
        wr(2'd1, 32'hFFFF_FFE5);
        rd(2'd1, v); check("R8 reserved zero", v, 32'h0000_0005);
        wr(2'd1, 32'h0);
        rd(2'd1, v); check("R8 cleared", v, 0);
    endtask

    task automatic t_causes();
        logic [31:0] v;
        for (int c = 0; c < 5; c++) begin
            term(3'(c));
            rd(2'd2, v); check("R6 status set", v, 32'(1 << c));
            check("R7 masked no irq", {31'b0, irq}, 0);
            rd(2'd0, v); check("R10 addr untouched", v, ref_addr);
            wr(2'd1, 32'(1 << c));
            check("R7 irq on enable", {31'b0, irq}, 1);
            wr(2'd1, 32'h0);
            wr(2'd2, 32'h1F);
            rd(2'd2, v); check("R9 cleared", v, 0);
        end
        for (int c = 5; c < 8; c++) begin
            term(3'(c));
            rd(2'd2, v); check("R6 bad code ignored", v, 0);
        end
    endtask

    task automatic t_w1c();
        logic [31:0] v;
        term(3'd1); term(3'd3); term(3'd4);
        wr(2'd1, 32'h0000_0008);
        check("R7 irq retry enabled", {31'b0, irq}, 1);
        wr(2'd2, 32'h0000_0008);
        rd(2'd2, v); check("R9 partial clear", v, 32'h0000_0012);
        check("R7 irq after clear", {31'b0, irq}, 0);
        @(negedge clk);
        wr_en = 1; wr_sel = 2'd2; wr_data = 32'h0000_0012;
        term_valid = 1; term_cause = 3'd1;
        @(negedge clk); wr_en = 0; term_valid = 0;
        rd(2'd2, v); check("R9 set beats clear", v, 32'h0000_0002);
        rd(2'd0, v); check("R10 addr after writes", v, ref_addr);
        wr(2'd2, 32'hFFFF_FFFF); wr(2'd1, 32'h0);
    endtask

    initial begin
        #(5.0 * 200000);
        if (!done) begin
            fails++;
            $display("FAIL watchdog expired");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        t_reset();
        t_beats();
        t_mixed();
        t_collision();
        t_wrap();
        t_enable_reserved();
        t_causes();
        t_w1c();
        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule